// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Ready-to-Send Flow Control

This block receives asynchronous serial characters. Each character has one low start bit, eight data bits with the least significant bit first, and one high stop bit. There is no parity bit. A local bit-rate generator sets the timing. A prescaler chooses either the system clock itself or the system clock divided by eight. A reload divider then divides that by (n+1) to give a tick, and each bit lasts sixteen ticks. The receiver samples the synchronized line in the middle of each bit. When a frame completes, the byte goes into a holding buffer. At the same moment a ready flag and a latched interrupt flag are raised.

Software reads the byte and pulses the read strobe, which frees the buffer. The interrupt flag has its own clear path: an acknowledge pulse or a software clear pulse. The flow-control output asks the far end to pause. It goes high as soon as a start edge is taken and stays high while a byte waits unread. The block also reports two errors. A framing error means the stop bit was low. An overrun means a frame ended while the buffer was still full.

Top module: `uart_rx_rts`

## Requirements
- R1: The tick period is (n+1) clocks when `psel`=0 and 8*(n+1) clocks when `psel`=1, where n is `brg_div`. One bit lasts 16 ticks, and each bit is sampled on its 8th tick, counted from the detected falling edge.
- R2: A frame is a low start bit, eight data bits with bit 0 first, and a high stop bit. The received byte appears on `rx_buf[7:0]` with the first data bit in position 0.
- R3: While `rx_en`=0, the receiver ignores falling edges on `rxd`. If `rx_en` drops during a frame, the frame is abandoned and no flag is raised.
- R4: If the start bit reads high at its mid-bit sample, the receiver returns to idle. It raises no flag, and `rts` goes back low.
- R5: `rts` is high within 4 clocks of a falling edge on `rxd` that starts a reception, and it stays high for the rest of that frame.
- R6: At the mid-point of the stop bit of a frame, the byte is copied into `rx_buf` and `rx_done` is set, provided `rx_done` was 0. A `buf_rd` pulse clears `rx_done`.
- R7: `rts` is high whenever `rx_done` is 1. With no frame in progress, `rts` goes low once `buf_rd` clears `rx_done`.
- R8: `irq_req` is set whenever a byte is copied into the buffer. An `irq_ack` pulse or an `irq_sw_clr` pulse clears it. `buf_rd` does not clear it.
- R9: If the stop bit reads low, the byte is still copied and `frm_err` is set. `buf_rd` clears `frm_err`.
- R10: If a frame ends while `rx_done` is 1, `ovr_err` is set, `rx_buf` keeps the earlier byte and `rx_done` stays 1. `buf_rd` clears `ovr_err`.
- R11: After reset, `rx_buf` is 0 and `rx_done`, `irq_req`, `rts`, `frm_err` and `ovr_err` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rxd | input | 1 | Serial receive line, idles high |
| rx_en | input | 1 | Receive enable |
| psel | input | 1 | Prescaler select: 0 = divide by 1, 1 = divide by 8 |
| brg_div | input | 8 | Reload divider setting n |
| buf_rd | input | 1 | One-cycle pulse: software has read the buffer |
| irq_ack | input | 1 | One-cycle interrupt acknowledge |
| irq_sw_clr | input | 1 | One-cycle software clear of the interrupt flag |
| rx_buf | output | 8 | Received byte |
| rx_done | output | 1 | Buffer holds an unread byte |
| irq_req | output | 1 | Latched interrupt request |
| rts | output | 1 | High means not ready: a reception is in progress or a byte is unread |
| frm_err | output | 1 | Stop bit of the buffered frame was low |
| ovr_err | output | 1 | A frame was lost because the buffer was full |

## Verification
The bench sends random bytes at random divider settings with both prescaler choices. A wrong divide ratio, a wrong bit order or a shifted sample point then shows up as a corrupted byte. Directed frames cover several error and control cases:
- a glitch that returns high before mid-start;
- a low stop bit;
- a second frame sent without reading the first;
- frames sent while the receiver is disabled, and a frame cut short by disabling it partway.

These separate the false-start, framing, overrun and enable rules from ordinary reception. Each of the three clear paths is pulsed on its own, which shows that the ready flag and the interrupt flag are released independently.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_DATA  = 2'd2,
    RX_STOP  = 2'd3
  } rx_state_e;

  // tick on which a bit is sampled (0-based phase counter value)
  function automatic logic is_mid(input int unsigned ph, input int unsigned ovs);
    return ph == (ovs / 2) - 1;
  endfunction

  // tick that closes a bit period
  function automatic logic is_last(input int unsigned ph, input int unsigned ovs);
    return ph == ovs - 1;
  endfunction

  // clocks per oversampling tick
  function automatic int unsigned tick_clocks(input int unsigned n, input logic slow,
                                              input int unsigned pre);
    return (n + 1) * (slow ? pre : 1);
  endfunction

endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rxd,
  output logic rxd_s,
  output logic fall
);
  logic [STAGES:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '1;
    else        sh <= {sh[STAGES-1:0], rxd};
  end

  assign rxd_s = sh[STAGES-1];
  assign fall  = sh[STAGES] & ~sh[STAGES-1];
endmodule

// File: rtl/uart_rx_brg.sv
module uart_rx_brg #(
  parameter int DIV_W   = 8,
  parameter int PRE_DIV = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             slow,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  localparam int PW = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;

  logic [PW-1:0]    pre_cnt;
  logic [DIV_W-1:0] div_cnt;
  logic             pre_en;

  assign pre_en = !slow || (pre_cnt == PW'(PRE_DIV - 1));
  assign tick   = run && pre_en && (div_cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt <= '0;
      div_cnt <= '0;
    end else if (!run) begin
      pre_cnt <= '0;
      div_cnt <= div;
    end else begin
      pre_cnt <= pre_en ? '0 : pre_cnt + 1'b1;
      if (pre_en) div_cnt <= (div_cnt == '0) ? div : div_cnt - 1'b1;
    end
  end
endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
  import uart_rx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              fall,
  input  logic              rxd_s,
  input  logic              tick,
  output logic              busy,
  output logic              frame_end,
  output logic              stop_ok,
  output logic [DATA_W-1:0] data
);
  localparam int PH_W = $clog2(OVS);
  localparam int BC_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

  rx_state_e        state;
  logic [PH_W-1:0]  phase;
  logic [BC_W-1:0]  bitn;
  logic [DATA_W-1:0] shreg;
  logic             mid, last;

  assign mid  = tick && is_mid(int'(phase), OVS);
  assign last = tick && is_last(int'(phase), OVS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= RX_IDLE;
      phase <= '0;
      bitn  <= '0;
      shreg <= '0;
    end else if (!en) begin
      state <= RX_IDLE;
      phase <= '0;
    end else begin
      if (state != RX_IDLE && tick) phase <= last ? '0 : phase + 1'b1;
      case (state)
        RX_IDLE: if (fall) begin
          state <= RX_START;
          phase <= '0;
        end
        RX_START: begin
          if (mid && rxd_s) state <= RX_IDLE;
          else if (last) begin
            state <= RX_DATA;
            bitn  <= '0;
          end
        end
        RX_DATA: begin
          if (mid) shreg <= {rxd_s, shreg[DATA_W-1:1]};
          if (last) begin
            if (bitn == BC_W'(DATA_W - 1)) state <= RX_STOP;
            else bitn <= bitn + 1'b1;
          end
        end
        RX_STOP: if (mid) state <= RX_IDLE;
        default: state <= RX_IDLE;
      endcase
    end
  end

  assign busy      = (state != RX_IDLE);
  assign frame_end = en && (state == RX_STOP) && mid;
  assign stop_ok   = rxd_s;
  assign data      = shreg;
endmodule

// File: rtl/uart_rx_rts.sv
module uart_rx_rts #(
  parameter int DATA_W  = 8,
  parameter int DIV_W   = 8,
  parameter int OVS     = 16,
  parameter int PRE_DIV = 8,
  parameter int SYNC_N  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rxd,
  input  logic              rx_en,
  input  logic              psel,
  input  logic [DIV_W-1:0]  brg_div,
  input  logic              buf_rd,
  input  logic              irq_ack,
  input  logic              irq_sw_clr,
  output logic [DATA_W-1:0] rx_buf,
  output logic              rx_done,
  output logic              irq_req,
  output logic              rts,
  output logic              frm_err,
  output logic              ovr_err
);
  logic rxd_s, fall, tick, busy, frame_end, stop_ok;
  logic load_evt, ovr_evt;
  logic [DATA_W-1:0] data;

  uart_rx_sync #(.STAGES(SYNC_N)) u_sync (
    .clk(clk), .rst_n(rst_n), .rxd(rxd), .rxd_s(rxd_s), .fall(fall)
  );

  uart_rx_brg #(.DIV_W(DIV_W), .PRE_DIV(PRE_DIV)) u_brg (
    .clk(clk), .rst_n(rst_n), .run(busy), .slow(psel), .div(brg_div), .tick(tick)
  );

  uart_rx_frame #(.DATA_W(DATA_W), .OVS(OVS)) u_frame (
    .clk(clk), .rst_n(rst_n), .en(rx_en), .fall(fall), .rxd_s(rxd_s), .tick(tick),
    .busy(busy), .frame_end(frame_end), .stop_ok(stop_ok), .data(data)
  );

  assign load_evt = frame_end && !rx_done;
  assign ovr_evt  = frame_end && rx_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_buf  <= '0;
      rx_done <= 1'b0;
      irq_req <= 1'b0;
      frm_err <= 1'b0;
      ovr_err <= 1'b0;
    end else begin
      if (load_evt) begin
        rx_buf  <= data;
        rx_done <= 1'b1;
        frm_err <= !stop_ok;
      end else if (buf_rd) begin
        rx_done <= 1'b0;
        frm_err <= 1'b0;
      end

      if (ovr_evt)     ovr_err <= 1'b1;
      else if (buf_rd) ovr_err <= 1'b0;

      if (load_evt)                     irq_req <= 1'b1;
      else if (irq_ack || irq_sw_clr)   irq_req <= 1'b0;
    end
  end

  assign rts = busy | rx_done;
endmodule

// File: rtl/uart_rx_rts_chk.sv
module uart_rx_rts_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rx_en,
  input logic              buf_rd,
  input logic              irq_ack,
  input logic              irq_sw_clr,
  input logic [DATA_W-1:0] rx_buf,
  input logic              rx_done,
  input logic              irq_req,
  input logic              rts,
  input logic              ovr_err,
  input logic              frame_end,
  input logic              load_evt,
  input logic              busy
);
  a_r7_rts_while_unread: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |-> rts);

  a_r5_rts_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> rts);

  a_r6_read_clears_done: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_rd && !load_evt) |=> !rx_done);

  a_r8_irq_on_load: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> (irq_req && rx_done));

  a_r8_irq_clears: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_ack || irq_sw_clr) && !load_evt) |=> !irq_req);

  a_r10_overrun_keeps_buf: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && rx_done) |=> (ovr_err && rx_done && $stable(rx_buf)));

  a_r3_disable_idles: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_en && !rx_done) |=> !rts);
endmodule

bind uart_rx_rts uart_rx_rts_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .buf_rd(buf_rd), .irq_ack(irq_ack),
  .irq_sw_clr(irq_sw_clr), .rx_buf(rx_buf), .rx_done(rx_done), .irq_req(irq_req),
  .rts(rts), .ovr_err(ovr_err), .frame_end(frame_end), .load_evt(load_evt), .busy(busy)
);

// File: tb/test_uart_rx_rts.sv
`timescale 1ns/1ps
module test_uart_rx_rts;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rxd = 1'b1;
  logic       rx_en = 1'b0;
  logic       psel = 1'b0;
  logic [7:0] brg_div = 8'd0;
  logic       buf_rd = 1'b0, irq_ack = 1'b0, irq_sw_clr = 1'b0;
  logic [7:0] rx_buf;
  logic       rx_done, irq_req, rts, frm_err, ovr_err;

  int compared = 0, mismatched = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  uart_rx_rts i_uart_rx_rts (
    .clk(clk), .rst_n(rst_n), .rxd(rxd), .rx_en(rx_en), .psel(psel), .brg_div(brg_div),
    .buf_rd(buf_rd), .irq_ack(irq_ack), .irq_sw_clr(irq_sw_clr), .rx_buf(rx_buf),
    .rx_done(rx_done), .irq_req(irq_req), .rts(rts), .frm_err(frm_err), .ovr_err(ovr_err)
  );

  // clocks per serial bit from the requirement: 16 ticks of (n+1)*prescale clocks
  function automatic int bit_clocks(input logic [7:0] n, input logic slow);
    return 16 * (int'(n) + 1) * (slow ? 8 : 1);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(ref logic sig);
    @(negedge clk); sig = 1'b1;
    @(negedge clk); sig = 1'b0;
  endtask

  task automatic send_frame(input logic [7:0] b, input logic stop);
    int bc;
    bc = bit_clocks(brg_div, psel);
    @(negedge clk); rxd = 1'b0;
    wait_clks(5);
    if (rx_en) check("R5 rts after start edge", rts, 1);
    wait_clks(bc - 5);
    for (int i = 0; i < 8; i++) begin
      rxd = b[i];
      wait_clks(bc);
    end
    rxd = stop;
    wait_clks(bc);
    rxd = 1'b1;
    wait_clks(bc);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [7:0] b;
    void'($urandom(32'h5eed1234));
    wait_clks(4);
    rst_n = 1'b1;
    wait_clks(2);
    // R11 reset state
    check("R11 rx_buf", rx_buf, 0);
    check("R11 rx_done", rx_done, 0);
    check("R11 irq_req", irq_req, 0);
    check("R11 rts", rts, 0);
    check("R11 frm_err", frm_err, 0);
    check("R11 ovr_err", ovr_err, 0);

    rx_en = 1'b1;
    brg_div = 8'd0; psel = 1'b0;
    send_frame(8'hA5, 1'b1);
    check("R2 byte A5", rx_buf, 8'hA5);
    check("R6 done set", rx_done, 1);
    check("R8 irq set", irq_req, 1);
    check("R7 rts held while unread", rts, 1);
    check("R9 no framing error", frm_err, 0);
    pulse(irq_ack);
    wait_clks(1);
    check("R8 ack clears irq", irq_req, 0);
    check("R6 ack leaves done", rx_done, 1);
    pulse(buf_rd);
    wait_clks(1);
    check("R6 read clears done", rx_done, 0);
    check("R7 rts low after read", rts, 0);

    // R1 R2 random rates and bytes
    for (int k = 0; k < 8; k++) begin
      psel = 1'($urandom % 2);
      brg_div = psel ? 8'($urandom % 3) : 8'($urandom % 6);
      b = 8'($urandom);
      send_frame(b, 1'b1);
      check("R1 R2 random byte", rx_buf, b);
      check("R6 done random", rx_done, 1);
      pulse(buf_rd);
      wait_clks(1);
      check("R8 read keeps irq", irq_req, 1);
      pulse(irq_sw_clr);
      wait_clks(1);
      check("R8 sw clear", irq_req, 0);
    end

    brg_div = 8'd1; psel = 1'b0;
    // R9 low stop bit
    send_frame(8'h3C, 1'b0);
    check("R9 byte still loaded", rx_buf, 8'h3C);
    check("R9 frm_err set", frm_err, 1);
    pulse(buf_rd);
    wait_clks(1);
    check("R9 read clears frm_err", frm_err, 0);
    pulse(irq_ack);

    // R10 overrun
    send_frame(8'h11, 1'b1);
    send_frame(8'h22, 1'b1);
    check("R10 old byte kept", rx_buf, 8'h11);
    check("R10 ovr_err set", ovr_err, 1);
    check("R10 done stays", rx_done, 1);
    pulse(buf_rd);
    wait_clks(1);
    check("R10 read clears ovr", ovr_err, 0);
    pulse(irq_ack);

    // R4 false start: low for 3 ticks only
    @(negedge clk); rxd = 1'b0;
    wait_clks(3 * 2);
    rxd = 1'b1;
    wait_clks(2 * bit_clocks(brg_div, psel));
    check("R4 rts back low", rts, 0);
    check("R4 no done", rx_done, 0);
    check("R4 no irq", irq_req, 0);

    // R3 disabled reception
    rx_en = 1'b0;
    send_frame(8'h5A, 1'b1);
    check("R3 disabled no done", rx_done, 0);
    check("R3 disabled rts", rts, 0);
    check("R3 disabled no irq", irq_req, 0);
    // R3 disable mid-frame
    rx_en = 1'b1;
    fork
      send_frame(8'h77, 1'b1);
      begin wait_clks(4 * bit_clocks(brg_div, psel)); rx_en = 1'b0; end
    join
    check("R3 aborted no done", rx_done, 0);
    check("R3 aborted rts", rts, 0);
    rx_en = 1'b1;
    send_frame(8'hC3, 1'b1);
    check("R3 recovers", rx_buf, 8'hC3);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule